// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit built from a row of identical one-bit slices. Each slice receives one bit of each operand, shared operand controls and a shared two-bit function code. Inside the slice a small decoder turns the code into one-hot strobes. The strobes enable exactly one of four function units onto a final OR stage: bitwise AND, bitwise OR, complement of B, or full-adder sum. Carries ripple from each slice into the next more significant one.

Before the function units see the operands, each operand passes through its own enable gate, and A can then be inverted. This lets the same slices clear a word, pass a constant of all ones, negate in two's complement, or increment. The increment input is the carry into the least significant slice. The word width is a parameter with a default of 8.

Top module: `alu_slice_chain`

## Requirements
- R1: With funcSel = 2'b00 the result is the bitwise AND of the conditioned operands A' and B', and carryOut is 0.
- R2: With funcSel = 2'b01 the result is the bitwise OR of A' and B'.
- R3: With funcSel = 2'b10 the result is the bitwise complement of B', and operand A has no effect on it.
- R4: With funcSel = 2'b11, {carryOut, result} equals A' + B' + incIn, computed as an unsigned sum WIDTH+1 bits wide.
- R5: When enableA is 0, A is forced to zero before inversion. With invertA = 1 as well, A' is therefore all ones.
- R6: When enableB is 0, B' is zero whatever opB holds.
- R7: When invertA is 1, A' is the bitwise complement of the gated A.
- R8: For the three logic functions (codes 00, 01 and 10), carryOut is 0 and incIn has no effect on the result.
- R9: With enableA = 1, invertA = 1, enableB = 0, incIn = 1 and funcSel = 2'b11, the result is the two's-complement negation of opA modulo 2^WIDTH.
- R10: A carry entering the least significant slice ripples through every slice. All-ones plus incIn gives a zero result with carryOut = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | Operand A |
| opB | input | WIDTH | Operand B |
| enableA | input | 1 | Pass A when 1; force it to zero when 0 |
| enableB | input | 1 | Pass B when 1; force it to zero when 0 |
| invertA | input | 1 | Complement the gated A when 1 |
| funcSel | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 SUM |
| incIn | input | 1 | Carry into the least significant slice |
| result | output | WIDTH | Result word |
| carryOut | output | 1 | Carry out of the most significant slice |

## Verification
Every result is due in the same cycle as its stimulus, because the block holds no registers. The only latency is the settling of the ripple carry through WIDTH slices. The bench applies each stimulus on the rising clock edge and samples result and carryOut on the following falling edge, half a period later, so the whole carry chain has settled before any comparison. A hand-worked vector table covers the named corner cases. A sweep then runs every combination of the control inputs and compares the outputs with a behavioural model written in the bench.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_SUM  = 2'b11
  } funcCode_e;

  // One-hot strobes from the slice decoder to the slice datapath
  typedef struct packed {
    logic enAnd;
    logic enOr;
    logic enNotB;
    logic enSum;
  } opStrobes_t;

  // Per-slice operand controls shared by all slices
  typedef struct packed {
    logic enableA;
    logic enableB;
    logic invertA;
  } operandCtl_t;

endpackage

// File: rtl/slice_decoder.sv
module slice_decoder
  import alu_slice_pkg::*;
(
  input  logic [1:0] funcSel,
  output opStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (funcCode_e'(funcSel))
      FN_AND:  strobes.enAnd  = 1'b1;
      FN_OR:   strobes.enOr   = 1'b1;
      FN_NOTB: strobes.enNotB = 1'b1;
      FN_SUM:  strobes.enSum  = 1'b1;
      default: strobes = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(funcSel)) begin
      // R1
      strobe_onehot_chk: assert ($countones(strobes) == 1)
        else $error("decoder strobes not one-hot for code %b", funcSel);
    end
  end

endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import alu_slice_pkg::*;
(
  input  logic        aBit,
  input  logic        bBit,
  input  operandCtl_t ctl,
  input  opStrobes_t  strobes,
  input  logic        carryIn,
  output logic        resBit,
  output logic        carryOutBit
);

  logic aGated;
  logic aCond;
  logic bCond;
  logic andOut;
  logic orOut;
  logic notBOut;
  logic sumOut;
  logic genCarry;

  // Operand conditioning: gate first, then optional inversion of A
  assign aGated = aBit & ctl.enableA;
  assign aCond  = aGated ^ ctl.invertA;
  assign bCond  = bBit & ctl.enableB;

  // Function units
  assign andOut   = aCond & bCond;
  assign orOut    = aCond | bCond;
  assign notBOut  = ~bCond;
  assign sumOut   = aCond ^ bCond ^ carryIn;
  assign genCarry = (aCond & bCond) | (carryIn & (aCond ^ bCond));

  // Final OR stage with only the decoded unit enabled onto it
  assign resBit = (strobes.enAnd  & andOut)
                | (strobes.enOr   & orOut)
                | (strobes.enNotB & notBOut)
                | (strobes.enSum  & sumOut);

  // Only the adder propagates carry
  assign carryOutBit = strobes.enSum & genCarry;

  always_comb begin
    if (!$isunknown({strobes, aBit, bBit, ctl, carryIn})) begin
      // R8
      logic_no_carry_chk: assert (strobes.enSum || !carryOutBit)
        else $error("carry produced by a logic function");
      // R6
      b_gate_chk: assert (ctl.enableB || !strobes.enNotB || resBit)
        else $error("disabled B not forced to zero");
    end
  end

endmodule

// File: rtl/bit_slice.sv
module bit_slice
  import alu_slice_pkg::*;
(
  input  logic        aBit,
  input  logic        bBit,
  input  operandCtl_t ctl,
  input  logic [1:0]  funcSel,
  input  logic        carryIn,
  output logic        resBit,
  output logic        carryOutBit
);

  opStrobes_t strobes;

  slice_decoder i_dec (
    .funcSel (funcSel),
    .strobes (strobes)
  );

  slice_datapath i_dp (
    .aBit        (aBit),
    .bBit        (bBit),
    .ctl         (ctl),
    .strobes     (strobes),
    .carryIn     (carryIn),
    .resBit      (resBit),
    .carryOutBit (carryOutBit)
  );

endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             enableA,
  input  logic             enableB,
  input  logic             invertA,
  input  logic [1:0]       funcSel,
  input  logic             incIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int CHAIN_LEN = WIDTH + 1;

  operandCtl_t         ctl;
  logic [CHAIN_LEN-1:0] carryChain;

  assign ctl           = '{enableA: enableA, enableB: enableB, invertA: invertA};
  assign carryChain[0] = incIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    bit_slice i_slice (
      .aBit        (opA[i]),
      .bBit        (opB[i]),
      .ctl         (ctl),
      .funcSel     (funcSel),
      .carryIn     (carryChain[i]),
      .resBit      (result[i]),
      .carryOutBit (carryChain[i+1])
    );
  end

  assign carryOut = carryChain[WIDTH];

  // Word-level checks of the chained slices against arithmetic
  logic [WIDTH-1:0] refA;
  logic [WIDTH-1:0] refB;
  logic [WIDTH:0]   refSum;

  always_comb begin
    refA   = (opA & {WIDTH{enableA}}) ^ {WIDTH{invertA}};
    refB   = opB & {WIDTH{enableB}};
    refSum = {1'b0, refA} + {1'b0, refB} + {{WIDTH{1'b0}}, incIn};
    if (!$isunknown({opA, opB, enableA, enableB, invertA, funcSel, incIn})) begin
      // R4
      sum_chain_chk: assert (funcSel != 2'b11 || {carryOut, result} == refSum)
        else $error("ripple sum mismatch");
      // R3
      notb_chk: assert (funcSel != 2'b10 || result == ~refB)
        else $error("complement of B mismatch");
      // R5
      a_gate_chk: assert (enableA || !invertA || funcSel != 2'b01 || result == '1)
        else $error("disabled A not forced to zero before inversion");
      // R8
      word_no_carry_chk: assert (funcSel == 2'b11 || !carryOut)
        else $error("carry out from logic function");
    end
  end

endmodule

// File: tb/test_alu_slice_chain.sv
module test_alu_slice_chain;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ea;
    logic         eb;
    logic         ia;
    logic [1:0]   sel;
    logic         inc;
    logic [W-1:0] expR;
    logic         expC;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 8'h0F, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 8'h05, 1'b0}, // R1
    '{8'hA5, 8'h0F, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 8'hAF, 1'b0}, // R2
    '{8'hA5, 8'h0F, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 8'hF0, 1'b0}, // R3
    '{8'h3C, 8'h01, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 8'h3D, 1'b0}, // R4
    '{8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 8'h00, 1'b1}, // R4
    '{8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 8'h00, 1'b1}, // R10
    '{8'h05, 8'h00, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 8'hFB, 1'b0}, // R9
    '{8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 8'h00, 1'b1}, // R9
    '{8'h77, 8'h00, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 8'hFF, 1'b0}, // R5
    '{8'h77, 8'h55, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 8'hFF, 1'b0}, // R6
    '{8'h0F, 8'hF0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 8'hF0, 1'b0}, // R7
    '{8'h80, 8'h80, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 8'h01, 1'b1}, // R4
    '{8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 2'b01, 1'b1, 8'hFF, 1'b0}  // R8
  };

  logic         clk = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         enableA = 1'b0;
  logic         enableB = 1'b0;
  logic         invertA = 1'b0;
  logic [1:0]   funcSel = 2'b00;
  logic         incIn = 1'b0;
  logic [W-1:0] result;
  logic         carryOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_slice_chain #(.WIDTH(W)) i_alu_slice_chain (
    .opA      (opA),
    .opB      (opB),
    .enableA  (enableA),
    .enableB  (enableB),
    .invertA  (invertA),
    .funcSel  (funcSel),
    .incIn    (incIn),
    .result   (result),
    .carryOut (carryOut)
  );

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ea, input logic eb, input logic ia,
                       input logic [1:0] sel, input logic inc);
    @(posedge clk);
    opA = a; opB = b; enableA = ea; enableB = eb;
    invertA = ia; funcSel = sel; incIn = inc;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] expR, input logic expC);
    checks++;
    if (result !== expR || carryOut !== expC) begin
      fails++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, result, carryOut, expR, expC);
    end
  endtask

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic ea, input logic eb, input logic ia,
                                       input logic [1:0] sel, input logic inc);
    logic [W-1:0] ac = (ea ? a : '0) ^ (ia ? '1 : '0);
    logic [W-1:0] bc = eb ? b : '0;
    case (sel)
      2'b00:   return {1'b0, ac & bc};
      2'b01:   return {1'b0, ac | bc};
      2'b10:   return {1'b0, ~bc};
      default: return {1'b0, ac} + {1'b0, bc} + {{W{1'b0}}, inc};
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [W:0] exp;
    logic [W-1:0] pairs [4];
    pairs[0] = 8'h00; pairs[1] = 8'hFF; pairs[2] = 8'h5A; pairs[3] = 8'hC3;

    // Quiescent state: all inputs low gives AND of zeros (R1)
    @(negedge clk);
    check("R1 idle", 8'h00, 1'b0);

    // Hand-worked vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].ea, VECS[i].eb, VECS[i].ia,
            VECS[i].sel, VECS[i].inc);
      check($sformatf("R1-table vector %0d", i), VECS[i].expR, VECS[i].expC);
    end

    // Sweep every control combination against the behavioural model (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int ctl = 0; ctl < 64; ctl++) begin
      for (int p = 0; p < 4; p++) begin
        logic [W-1:0] a = pairs[p] ^ 8'h3C;
        logic [W-1:0] b = pairs[3-p];
        apply(a, b, ctl[0], ctl[1], ctl[2], ctl[4:3], ctl[5]);
        exp = model(a, b, ctl[0], ctl[1], ctl[2], ctl[4:3], ctl[5]);
        check($sformatf("R4 sweep ctl=%0d", ctl), exp[W-1:0], exp[W]);
      end
    end

    // R9: negation of every operand value
    for (int v = 0; v < 256; v++) begin
      apply(W'(v), 8'hA5, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1);
      check("R9 negate", W'(-v), (v == 0));
    end

    // R3: A has no effect on NOT B
    apply(8'h00, 8'h3C, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1);
    check("R3 A ignored", 8'hC3, 1'b0);
    apply(8'hFF, 8'h3C, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0);
    check("R3 A ignored", 8'hC3, 1'b0);

    // R10: long ripple with B contributing
    apply(8'h7F, 8'h80, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1);
    check("R10 full ripple", 8'h00, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule